// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block runs the fast address and data cycles of an enhanced parallel port. A CPU-side access to the address-cycle offset or the data-cycle offset becomes one or more byte handshakes with an attached peripheral. Each handshake uses a request/acknowledge pair. The block keeps the port's control word. A cycle is started only when that word selects exactly the mode that matches the transfer's direction. Any other access is quietly discarded. Wide data accesses are split into byte handshakes, lowest byte first.

Each handshake is watched by a cycle counter. When the acknowledge does not come in time, a sticky timeout flag is set and the bytes still outstanding are abandoned. The flag is shown as bit 0 of the status view. Software clears it by writing a one to that bit. The CPU access is held off until the whole transfer has finished, and `bus_ready` then pulses for one cycle.

Top module: `epp_port`

## Requirements
- R1: After reset the timeout flag is 0, the control word reads 0xCC, `per_req` and `bus_ready` are low, and `data_dir` is 0.
- R2: A write to offset 3 or 4 starts peripheral cycles only if (control & 0x2F) == 0x04. Otherwise no request is issued and nothing else changes.
- R3: A read from offset 3 or 4 starts peripheral cycles only if (control & 0x2F) == 0x24. Otherwise it issues no request and returns all ones at the access width: 0xFF, 0xFFFF or 0xFFFFFFFF.
- R4: Offset 3 runs exactly one byte cycle with `per_addr_cyc` = 1. Offset 4 runs data cycles with `per_addr_cyc` = 0.
- R5: At offset 4, `bus_size` 0 moves 1 byte, 1 moves 2 bytes, 2 moves 4 bytes, and 3 moves 1 byte. Bytes are sent and assembled least significant first.
- R6: If `per_ack` is not seen within TIMEOUT_CYCLES clock edges after a request rises, the timeout flag is set. An acknowledge seen on exactly the last allowed edge counts as success.
- R7: Reading status (offset 1) returns `pin_status[7:1]` with the timeout flag in bit 0, and `status_view` shows the same value.
- R8: The timeout flag is sticky. Successful transfers leave it set. Only a status write with bit 0 = 1 clears it, and a status write with bit 0 = 0 has no effect.
- R9: `bus_ready` is a one-cycle pulse issued after the last byte completes or after the first timeout. Bytes after a timeout are not requested, and read bytes not received return 0xFF.
- R10: A control write (offset 2) stores the written value OR 0xC0, which reads back at offset 2. When bit 5 changes, `data_dir` takes the new value one cycle before `ctrl_word` does.
- R11: `per_req` falls for at least one cycle after each acknowledged byte before the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | CPU access request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_size | input | 2 | Access size code (see R5) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | One-cycle completion pulse |
| pin_status | input | 8 | Status lines driven by the peripheral |
| status_view | output | 8 | Status with the timeout flag in bit 0 |
| ctrl_word | output | 8 | Stored control word |
| data_dir | output | 1 | Data pin direction, 1 = input |
| per_req | output | 1 | Byte cycle request |
| per_addr_cyc | output | 1 | 1 = address cycle, 0 = data cycle |
| per_write | output | 1 | 1 = byte goes to the peripheral |
| per_wbyte | output | 8 | Byte being written |
| per_ack | input | 1 | Peripheral acknowledge |
| per_rbyte | input | 8 | Byte returned by the peripheral |

## Verification
The assertions watch, on every cycle, the following properties:
- every rising request has the correct control-word gate for its direction;
- address cycles never go past the first byte;
- a request always drops after an acknowledge;
- the timeout flag only rises out of an unanswered handshake and only falls on a status write with bit 0 set;
- `data_dir` and `ctrl_word` bit 5 disagree only while a control write is in flight;
- the ready pulse lasts one cycle.

Only the bench's scenarios can show the following:
- byte order and the reassembled read value;
- the all-ones fill for dropped reads and for bytes lost after a timeout;
- the exact edge where a late acknowledge turns into a timeout;
- the values read back from status and control.

// File: rtl/epp_pkg.sv
package epp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_GAP,
    ST_CTLW,
    ST_DONE
  } epp_state_e;

  localparam int          BUS_BYTES   = 4;
  localparam int          BUS_W       = 8 * BUS_BYTES;
  localparam int          CNT_W       = $clog2(BUS_BYTES) + 1;
  localparam logic [7:0]  GATE_MASK   = 8'h2F;
  localparam logic [7:0]  GATE_WRITE  = 8'h04;
  localparam logic [7:0]  GATE_READ   = 8'h24;
  localparam logic [7:0]  CTRL_FORCED = 8'hC0;
  localparam logic [7:0]  CTRL_RESET  = 8'hCC;
  localparam int          DIR_BIT     = 5;

  localparam logic [2:0]  OFS_STATUS  = 3'd1;
  localparam logic [2:0]  OFS_CTRL    = 3'd2;
  localparam logic [2:0]  OFS_EADDR   = 3'd3;
  localparam logic [2:0]  OFS_EDATA   = 3'd4;

  // number of bytes moved for a size code
  function automatic logic [CNT_W-1:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd1:    return CNT_W'(2);
      2'd2:    return CNT_W'(4);
      default: return CNT_W'(1);
    endcase
  endfunction

  // all-ones value at an access width given in bytes
  function automatic logic [BUS_W-1:0] width_fill(input logic [CNT_W-1:0] n);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int b = 0; b < BUS_BYTES; b++)
      if (b < int'(n)) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  // exact-match mode gate, different for each direction
  function automatic logic mode_allows(input logic [7:0] ctrl, input logic is_write);
    return (ctrl & GATE_MASK) == (is_write ? GATE_WRITE : GATE_READ);
  endfunction

  // byte lane selection, lane 0 is least significant
  function automatic logic [7:0] lane_of(input logic [BUS_W-1:0] d,
                                         input logic [CNT_W-1:0] i);
    logic [7:0] r;
    r = 8'h00;
    for (int b = 0; b < BUS_BYTES; b++)
      if (int'(i) == b) r = d[8*b +: 8];
    return r;
  endfunction

endpackage

// File: rtl/epp_gate.sv
module epp_gate
  import epp_pkg::*;
(
  input  logic [7:0] ctrl,
  input  logic       is_write,
  input  logic [2:0] offset,
  output logic       is_cycle_ofs,
  output logic       open_ok
);
  assign is_cycle_ofs = (offset == OFS_EADDR) || (offset == OFS_EDATA);
  assign open_ok      = is_cycle_ofs && mode_allows(ctrl, is_write);
endmodule

// File: rtl/epp_timer.sv
module epp_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic expired
);
  localparam int TW = $clog2(LIMIT) + 1;
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt;

  assign expired = run && !ack && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || ack) cnt <= '0;
    else if (cnt != LAST)      cnt <= cnt + 1'b1;
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/epp_ctrlreg.sv
module epp_ctrlreg
  import epp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wr_val,
  output logic [7:0] ctrl_q,
  output logic       dir_q,
  output logic       busy
);
  logic [7:0] pend_q;
  logic [7:0] forced;
  logic       dir_flip;

  assign forced   = wr_val | CTRL_FORCED;
  assign dir_flip = wr && (forced[DIR_BIT] != ctrl_q[DIR_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      dir_q  <= CTRL_RESET[DIR_BIT];
      pend_q <= CTRL_RESET;
      busy   <= 1'b0;
    end else if (busy) begin
      ctrl_q <= pend_q;
      busy   <= 1'b0;
    end else if (dir_flip) begin
      dir_q  <= forced[DIR_BIT];
      pend_q <= forced;
      busy   <= 1'b1;
    end else if (wr) begin
      ctrl_q <= forced;
    end
  end

  // direction leads the rest of the word only while a flip is pending
  assert_dir_lead_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q != ctrl_q[DIR_BIT]) |-> busy);
  assert_forced_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7:6] == 2'b11);
endmodule

// File: rtl/epp_port.sv
module epp_port
  import epp_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ready,
  input  logic [7:0]  pin_status,
  output logic [7:0]  status_view,
  output logic [7:0]  ctrl_word,
  output logic        data_dir,
  output logic        per_req,
  output logic        per_addr_cyc,
  output logic        per_write,
  output logic [7:0]  per_wbyte,
  input  logic        per_ack,
  input  logic [7:0]  per_rbyte
);
  epp_state_e        state;
  logic              op_we, op_addr;
  logic [CNT_W-1:0]  nbytes, idx;
  logic [BUS_W-1:0]  wdata_q, rdata_q;
  logic              tmo_flag;

  // named internal events
  logic              accept;
  logic              is_cyc_ofs, gate_ok;
  logic [CNT_W-1:0]  acc_bytes;
  logic              tmr_expired;
  logic              last_byte;
  logic              tmo_event;
  logic              tmo_clear;
  logic              ctl_wr, ctl_busy;
  logic [7:0]        ctrl_q;

  assign accept    = (state == ST_IDLE) && bus_req;
  assign acc_bytes = (bus_addr == OFS_EDATA) ? size_bytes(bus_size) : CNT_W'(1);
  assign last_byte = (idx == nbytes - CNT_W'(1));
  assign tmo_event = tmr_expired;
  assign tmo_clear = accept && bus_we && (bus_addr == OFS_STATUS) && bus_wdata[0];
  assign ctl_wr    = accept && bus_we && (bus_addr == OFS_CTRL);

  epp_gate u_gate (
    .ctrl         (ctrl_q),
    .is_write     (bus_we),
    .offset       (bus_addr),
    .is_cycle_ofs (is_cyc_ofs),
    .open_ok      (gate_ok)
  );

  epp_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == ST_XFER),
    .ack     (per_ack),
    .expired (tmr_expired)
  );

  epp_ctrlreg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (ctl_wr),
    .wr_val (bus_wdata[7:0]),
    .ctrl_q (ctrl_q),
    .dir_q  (data_dir),
    .busy   (ctl_busy)
  );

  assign status_view  = {pin_status[7:1], tmo_flag};
  assign ctrl_word    = ctrl_q;
  assign per_req      = (state == ST_XFER);
  assign per_addr_cyc = op_addr;
  assign per_write    = op_we;
  assign per_wbyte    = lane_of(wdata_q, idx);
  assign bus_ready    = (state == ST_DONE);
  assign bus_rdata    = rdata_q;

  // sticky timeout flag
  always_ff @(posedge clk) begin
    if (!rst_n)         tmo_flag <= 1'b0;
    else if (tmo_event) tmo_flag <= 1'b1;
    else if (tmo_clear) tmo_flag <= 1'b0;
  end

  // access sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_we   <= 1'b0;
      op_addr <= 1'b0;
      nbytes  <= CNT_W'(1);
      idx     <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op_we   <= bus_we;
          op_addr <= (bus_addr == OFS_EADDR);
          nbytes  <= acc_bytes;
          idx     <= '0;
          wdata_q <= bus_wdata;
          if (gate_ok) begin
            rdata_q <= bus_we ? '0 : width_fill(acc_bytes);
            state   <= ST_XFER;
          end else if (is_cyc_ofs) begin
            rdata_q <= bus_we ? '0 : width_fill(acc_bytes);
            state   <= ST_DONE;
          end else if (bus_addr == OFS_STATUS) begin
            rdata_q <= bus_we ? '0 : {24'h0, status_view};
            state   <= ST_DONE;
          end else if (bus_addr == OFS_CTRL) begin
            rdata_q <= bus_we ? '0 : {24'h0, ctrl_q};
            state   <= bus_we ? ST_CTLW : ST_DONE;
          end else begin
            rdata_q <= bus_we ? '0 : 32'h0000_00FF;
            state   <= ST_DONE;
          end
        end
        ST_XFER: begin
          if (per_ack) begin
            if (!op_we)
              for (int b = 0; b < BUS_BYTES; b++)
                if (int'(idx) == b) rdata_q[8*b +: 8] <= per_rbyte;
            if (last_byte) state <= ST_DONE;
            else begin
              idx   <= idx + 1'b1;
              state <= ST_GAP;
            end
          end else if (tmr_expired) begin
            state <= ST_DONE;
          end
        end
        ST_GAP:  state <= ST_XFER;
        ST_CTLW: if (!ctl_busy) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_wr_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(per_req) && per_write) |-> ((ctrl_word & GATE_MASK) == GATE_WRITE));
  assert_rd_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(per_req) && !per_write) |-> ((ctrl_word & GATE_MASK) == GATE_READ));
  assert_addr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_req && per_addr_cyc) |-> (idx == '0));
  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    per_req |-> (idx < nbytes));
  assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(per_req && !per_ack));
  assert_flag_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo_flag) |-> $past(bus_req && bus_we && bus_addr == OFS_STATUS && bus_wdata[0]));
  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);
  assert_no_req_after_tmo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (per_req && tmr_expired) |=> !per_req);
  assert_req_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (per_req && per_ack) |=> !per_req);
endmodule

// File: tb/sim_epp_port.sv
module sim_epp_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [7:0]  pin_status = 8'hF8;
  logic [7:0]  status_view, ctrl_word;
  logic        data_dir, per_req, per_addr_cyc, per_write;
  logic [7:0]  per_wbyte;
  logic        per_ack = 1'b0;
  logic [7:0]  per_rbyte = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  // peripheral model settings
  int          ack_delay = 1;  // 0 = never acknowledge
  int          ack_limit = 8;
  int          served = 0;
  int          wait_cnt = 0;
  logic [31:0] rd_src = '0;
  logic        prev_req = 1'b0;
  logic [9:0]  exp_q[$];        // {addr_cyc, write, byte}
  // direction ordering monitor
  bit          saw_lead = 0, saw_bad = 0;

  always #10 clk = ~clk;

  epp_port u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor + peripheral model, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (data_dir != ctrl_word[5] && data_dir) saw_lead = 1;
      if (ctrl_word[5] && !data_dir) saw_bad = 1;
      if (per_req && !prev_req) begin
        if (exp_q.size() == 0)
          check(0, "R2/R3 unexpected request", {22'h0, per_addr_cyc, per_write, per_wbyte}, 32'h0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check(per_addr_cyc == e[9] && per_write == e[8] && (!e[8] || per_wbyte == e[7:0]),
                "R4/R5 request item", {22'h0, per_addr_cyc, per_write, per_wbyte}, {22'h0, e});
        end
      end
      prev_req = per_req;
      if (per_ack) per_ack = 1'b0;
      else if (per_req) begin
        wait_cnt++;
        if (ack_delay != 0 && served < ack_limit && wait_cnt == ack_delay) begin
          per_ack   = 1'b1;
          per_rbyte = rd_src[8*served +: 8];
          served++;
          wait_cnt = 0;
        end
      end else wait_cnt = 0;
    end
  end

  task automatic access(input logic we, input logic [2:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    served = 0;
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (bus_ready) break;
    end
    rd = bus_rdata;
    bus_req = 1'b0;
    @(negedge clk);
    check(!bus_ready, "R9 ready single pulse", {31'h0, bus_ready}, 32'h0);
  endtask

  task automatic push(input logic ac, input logic wr, input logic [7:0] b);
    exp_q.push_back({ac, wr, b});
  endtask

  task automatic queue_empty(input string tag);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(bus_ready == 0 && per_req == 0, "R1 idle outputs", {bus_ready, per_req}, 0);
    check(ctrl_word == 8'hCC, "R1 control reset", ctrl_word, 8'hCC);
    check(data_dir == 0, "R1 direction reset", data_dir, 0);
    rst_n = 1'b1;
    access(0, 3'd1, 0, 0, r);
    check(r == 32'hF8, "R1 R7 status after reset", r, 32'hF8);

    // R2 R3 dropped with reset control
    access(1, 3'd3, 0, 32'h5A, r);
    queue_empty("R2 dropped addr write");
    access(0, 3'd4, 2'd1, 0, r);
    check(r == 32'h0000FFFF, "R3 dropped 2-byte read", r, 32'hFFFF);

    // R10 control write with forced bits
    access(1, 3'd2, 0, 32'h04, r);
    access(0, 3'd2, 0, 0, r);
    check(r == 32'hC4, "R10 control readback", r, 32'hC4);

    // R4 R5 write cycles
    push(1, 1, 8'h5A);
    access(1, 3'd3, 2'd2, 32'h0000005A, r);
    queue_empty("R4 address cycle one byte");
    push(0, 1, 8'h44); push(0, 1, 8'h33); push(0, 1, 8'h22); push(0, 1, 8'h11);
    access(1, 3'd4, 2'd2, 32'h11223344, r);
    queue_empty("R5 four byte write LSB first");
    push(0, 1, 8'hBB); push(0, 1, 8'hAA);
    access(1, 3'd4, 2'd1, 32'h9988AABB, r);
    queue_empty("R5 two byte write");
    push(0, 1, 8'h77);
    access(1, 3'd4, 2'd3, 32'h55667777, r);
    queue_empty("R5 size code 3 is one byte");

    // R3 read gated off in write mode
    access(0, 3'd4, 2'd2, 0, r);
    check(r == 32'hFFFFFFFF, "R3 read in write mode", r, 32'hFFFFFFFF);
    queue_empty("R3 no request");

    // R10 direction change ordering
    saw_lead = 0; saw_bad = 0;
    access(1, 3'd2, 0, 32'h24, r);
    check(saw_lead && !saw_bad, "R10 direction leads control", {saw_lead, saw_bad}, 2'b10);
    check(ctrl_word == 8'hE4 && data_dir, "R10 final control", ctrl_word, 8'hE4);

    // R5 reads
    rd_src = 32'hA1B2C3D4;
    push(0, 0, 0); push(0, 0, 0); push(0, 0, 0); push(0, 0, 0);
    access(0, 3'd4, 2'd2, 0, r);
    check(r == 32'hA1B2C3D4, "R5 four byte read assembly", r, 32'hA1B2C3D4);
    queue_empty("R5 four read requests");
    rd_src = 32'h0000003C;
    push(1, 0, 0);
    access(0, 3'd3, 0, 0, r);
    check(r == 32'h3C, "R4 address read", r, 32'h3C);

    // R2 write in read mode dropped
    access(1, 3'd4, 0, 32'h12, r);
    queue_empty("R2 write in read mode");
    // strobe set breaks exact match
    access(1, 3'd2, 0, 32'h25, r);
    access(0, 3'd4, 0, 0, r);
    check(r == 32'hFF, "R3 extra control bit blocks read", r, 32'hFF);
    queue_empty("R3 no request with strobe");

    // R6 boundary: ack on last allowed edge
    access(1, 3'd2, 0, 32'h04, r);
    ack_delay = 16;
    push(0, 1, 8'h01);
    access(1, 3'd4, 0, 32'h01, r);
    access(0, 3'd1, 0, 0, r);
    check(r[0] == 0, "R6 ack at limit succeeds", r, 32'hF8);
    ack_delay = 17;
    push(0, 1, 8'h02);
    access(1, 3'd4, 0, 32'h02, r);
    pin_status = 8'hA0;
    access(0, 3'd1, 0, 0, r);
    check(r == 32'hA1, "R6 R7 late ack times out", r, 32'hA1);
    check(status_view == 8'hA1, "R7 status view", status_view, 8'hA1);

    // R8 sticky
    ack_delay = 2;
    push(0, 1, 8'h03);
    access(1, 3'd4, 0, 32'h03, r);
    access(1, 3'd1, 0, 32'hFE, r);
    access(0, 3'd1, 0, 0, r);
    check(r[0] == 1, "R8 flag sticky over success and bit0=0 write", r, 32'hA1);
    access(1, 3'd1, 0, 32'h01, r);
    pin_status = 8'hA1;
    access(0, 3'd1, 0, 0, r);
    check(r == 32'hA0, "R7 R8 flag cleared, pin bit0 replaced", r, 32'hA0);

    // R9 partial read: one byte then timeout, rest skipped
    access(1, 3'd2, 0, 32'h24, r);
    ack_limit = 1; rd_src = 32'h000000B0;
    push(0, 0, 0); push(0, 0, 0);
    access(0, 3'd4, 2'd2, 0, r);
    check(r == 32'hFFFFFFB0, "R9 partial read fill", r, 32'hFFFFFFB0);
    queue_empty("R9 remaining bytes skipped");
    access(0, 3'd1, 0, 0, r);
    check(r[0] == 1, "R6 partial timeout flag", r, 32'hA1);

    // R11 handled by per-request accounting; multi-byte with slow ack
    ack_limit = 8; ack_delay = 3; rd_src = 32'h00001234;
    push(0, 0, 0); push(0, 0, 0);
    access(0, 3'd4, 2'd1, 0, r);
    check(r == 32'h1234, "R11 separate requests per byte", r, 32'h1234);
    queue_empty("R11 two rising requests");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule